// File: doc/BRIEF.md
# Padded Vertex Count Calculator

This unit turns a draw's vertex count into the number of thread slots the dispatcher actually launches per instance. The padded count is always an odd factor of 1, 3, 5, 7 or 9 multiplied by a power of two. A divider that only handles those factors can then split a linear thread index into vertex and instance parts. The padded count is always a multiple of four, and it is always strictly larger than the request, even when the request already lies on that grid.

For each count the unit reports three things: the padded count, the odd factor as an index `m` (odd = 2m + 1), and the total power-of-two exponent. Software uses the pair (`m`, exponent) to program per-vertex modulo addressing. The rule has two parts:

- Small counts (below 20) round up to the next multiple of four.
- Larger counts take the leading one and the three bits beneath it as a 4-bit pattern, and look the grid point up in a fixed table.

Any result that would not fit in the count width is flagged, and the numeric outputs are zeroed. The unit is a single pipeline register behind combinational logic. It takes a new count every cycle and gives the answer one cycle later.

Top module: `pad_vtx_count`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero after that edge.
- R2: The outputs present the result for the count sampled at the previous rising edge (one cycle of latency), and a new count is accepted every cycle.
- R3: For counts below 20, the padded count is the smallest multiple of four strictly greater than the count, so 0, 1, 2 and 3 all give 4.
- R4: For counts of 20 or more, let p be the position of the leading one and n = p - 3. If bits p..p-3 read 1000, the result is 9·2^n, reported as m = 4 and exponent n (so 70 gives 72, m = 4, exponent 3).
- R5: Leading pattern 1001 gives 5·2^(n+1), reported as m = 2 and exponent n+1.
- R6: Leading pattern 101x gives 3·2^(n+2), reported as m = 1 and exponent n+2.
- R7: Leading pattern 110x gives 7·2^(n+1), reported as m = 3 and exponent n+1.
- R8: Leading pattern 111x gives 2^(n+4), reported as m = 0 and exponent n+4.
- R9: Whenever no overflow is flagged, the padded count is a multiple of four and strictly greater than the count.
- R10: Whenever no overflow is flagged, the padded count equals (2m+1) shifted left by the exponent, with m in the range 0 to 4.
- R11: The overflow flag is high exactly when the padded value would be 2^W or more. For the default W = 32 this happens exactly when the top three count bits are all ones. While the flag is high, the padded count, m and the exponent are all zero.
- R12: The exponent holds the whole power of two left after the odd factor is removed, including in the small range. So count 9 gives 12 (m = 1, exponent 2), and count 12 gives 16 (m = 0, exponent 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vtx_count | input | W | Requested vertex count, unsigned |
| pad_count | output | W | Padded thread count (zero on overflow) |
| pad_shift | output | $clog2(W+1) | Power-of-two exponent of the padded count |
| pad_odd_idx | output | 3 | Odd factor index m, odd = 2m+1 |
| pad_ovf | output | 1 | Padded value does not fit in W bits |

## Verification
The cases that are hard to reach are the pattern rows whose leading one sits high in a 32-bit word, together with the narrow overflow band near the top of the range. A plain sweep from zero never gets there. The bench sweeps every count below 4096 exhaustively. It then places the leading one at every position from 4 to 31, combines each position with all eight 4-bit leading patterns and three different fills of the lower bits, and adds explicit counts on both sides of the overflow edge. Expected results come from a 64-bit arithmetic model in the bench.

// File: rtl/pvc_pkg.sv
// Package pvc_pkg
// Shared types and constants for the padded vertex count calculator.
// Assumes nothing beyond standard SystemVerilog packages.
package pvc_pkg;

    // Index of the odd factor; the factor itself is 2*index + 1.
    typedef enum logic [2:0] {
        ODD_1 = 3'd0,
        ODD_3 = 3'd1,
        ODD_5 = 3'd2,
        ODD_7 = 3'd3,
        ODD_9 = 3'd4
    } odd_idx_e;

    // Counts strictly below this use the round-to-next-four rule.
    localparam int unsigned SMALL_LIMIT = 20;

    // Odd factor value as a 4-bit number.
    function automatic logic [3:0] odd_value(input odd_idx_e idx);
        return {idx, 1'b1};
    endfunction

endpackage

// File: rtl/pvc_lead_one.sv
// Module pvc_lead_one
// Finds the bit position of the most significant set bit of din.
// Assumes W >= 2. pos is zero when din is zero (flagged by any_set = 0).
module pvc_lead_one #(
    parameter int W  = 32,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    output logic [PW-1:0] pos,
    output logic          any_set
);

    // Priority scan: the highest set bit wins.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (din[i]) pos = PW'(i);
        end
    end

    // Any bit set at all.
    assign any_set = |din;

endmodule

// File: rtl/pvc_grid_select.sv
// Module pvc_grid_select
// Chooses the grid point (odd factor index and exponent) for a count.
// Small counts round to the next multiple of four; larger counts are
// decoded from the leading one and the three bits under it.
// Assumes W >= 8 and that msb_pos is the leading-one position of count.
module pvc_grid_select
    import pvc_pkg::*;
#(
    parameter int W  = 32,
    localparam int PW = $clog2(W),
    localparam int SW = $clog2(W + 1)
) (
    input  logic [W-1:0]  count,
    input  logic [PW-1:0] msb_pos,
    output odd_idx_e      odd_idx,
    output logic [SW-1:0] shift
);

    logic          is_small;
    logic [2:0]    quad_next;
    logic [PW-1:0] low_pos;
    logic [3:0]    lead_pat;
    logic [SW-1:0] n_sh;
    odd_idx_e      small_idx;
    logic [SW-1:0] small_sh;
    odd_idx_e      big_idx;
    logic [SW-1:0] big_sh;

    // Range selection between the two rules.
    assign is_small = (count < W'(SMALL_LIMIT));

    // Small rule: quotient by four plus one (1..5) gives padded/4.
    assign quad_next = count[4:2] + 3'd1;

    // Factor padded/4 = k into odd part and total exponent.
    always_comb begin
        case (quad_next)
            3'd1:    begin small_idx = ODD_1; small_sh = SW'(2); end
            3'd2:    begin small_idx = ODD_1; small_sh = SW'(3); end
            3'd3:    begin small_idx = ODD_3; small_sh = SW'(2); end
            3'd4:    begin small_idx = ODD_1; small_sh = SW'(4); end
            default: begin small_idx = ODD_5; small_sh = SW'(2); end
        endcase
    end

    // Large rule: the 4-bit pattern starting at the leading one.
    assign low_pos  = msb_pos - PW'(3);
    assign lead_pat = 4'(count >> low_pos);
    assign n_sh     = SW'(low_pos);

    // Pattern table: pick the odd factor and add its extra exponent.
    always_comb begin
        case (lead_pat[2:1])
            2'b00: begin
                if (lead_pat[0]) begin big_idx = ODD_5; big_sh = n_sh + SW'(1); end
                else             begin big_idx = ODD_9; big_sh = n_sh;          end
            end
            2'b01:   begin big_idx = ODD_3; big_sh = n_sh + SW'(2); end
            2'b10:   begin big_idx = ODD_7; big_sh = n_sh + SW'(1); end
            default: begin big_idx = ODD_1; big_sh = n_sh + SW'(4); end
        endcase
    end

    // Final selection between rules.
    assign odd_idx = is_small ? small_idx : big_idx;
    assign shift   = is_small ? small_sh  : big_sh;

endmodule

// File: rtl/pvc_scale.sv
// Module pvc_scale
// Builds the padded count from odd factor and exponent and detects
// results that do not fit in W bits.
// Assumes shift <= W, which the grid selector guarantees.
module pvc_scale
    import pvc_pkg::*;
#(
    parameter int W  = 32,
    localparam int SW = $clog2(W + 1),
    localparam int WW = W + 4
) (
    input  odd_idx_e      odd_idx,
    input  logic [SW-1:0] shift,
    output logic [W-1:0]  padded,
    output logic          overflow
);

    logic [WW-1:0] wide;

    // Widened product so the top bits expose any overflow.
    assign wide     = WW'(odd_value(odd_idx)) << shift;
    assign padded   = wide[W-1:0];
    assign overflow = |wide[WW-1:W];

endmodule

// File: rtl/pad_vtx_count.sv
// Module pad_vtx_count
// Top level: registers the padded vertex count, its odd factor index and
// its exponent one cycle after the count is sampled. Overflowing results
// are flagged and their numeric outputs forced to zero.
// Assumes W >= 8. Reset is synchronous and active low.
module pad_vtx_count
    import pvc_pkg::*;
#(
    parameter int W  = 32,
    localparam int PW = $clog2(W),
    localparam int SW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  vtx_count,
    output logic [W-1:0]  pad_count,
    output logic [SW-1:0] pad_shift,
    output logic [2:0]    pad_odd_idx,
    output logic          pad_ovf
);

    logic [PW-1:0] msb_pos;
    logic          msb_any;
    odd_idx_e      sel_idx;
    logic [SW-1:0] sel_shift;
    logic [W-1:0]  sel_padded;
    logic          sel_ovf;
    logic          out_live;

    pvc_lead_one #(.W(W)) u_lead (
        .din     (vtx_count),
        .pos     (msb_pos),
        .any_set (msb_any)
    );

    pvc_grid_select #(.W(W)) u_grid (
        .count   (vtx_count),
        .msb_pos (msb_pos),
        .odd_idx (sel_idx),
        .shift   (sel_shift)
    );

    pvc_scale #(.W(W)) u_scale (
        .odd_idx  (sel_idx),
        .shift    (sel_shift),
        .padded   (sel_padded),
        .overflow (sel_ovf)
    );

    // Output register stage; overflow zeroes the numeric fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_count   <= '0;
            pad_shift   <= '0;
            pad_odd_idx <= '0;
            pad_ovf     <= 1'b0;
        end else begin
            pad_count   <= sel_ovf ? '0 : sel_padded;
            pad_shift   <= sel_ovf ? '0 : sel_shift;
            pad_odd_idx <= sel_ovf ? '0 : sel_idx;
            pad_ovf     <= sel_ovf;
        end
    end

    // Marks that the output register holds a computed result.
    always_ff @(posedge clk) begin
        if (!rst_n) out_live <= 1'b0;
        else        out_live <= 1'b1;
    end

    // msb_any is informational only: zero counts take the small path.
    logic unused_any;
    assign unused_any = msb_any;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (pad_count == '0 && pad_shift == '0 && pad_odd_idx == 3'd0 && !pad_ovf)); // R1

    AST_ABOVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n) (out_live && !pad_ovf) |-> (pad_count > $past(vtx_count) && pad_count[1:0] == 2'b00)); // R9

    AST_GRID_FORM: assert property (@(posedge clk) disable iff (!rst_n) (out_live && !pad_ovf) |-> (pad_odd_idx <= 3'd4 && pad_count == (W'({pad_odd_idx, 1'b1}) << pad_shift))); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pad_ovf |-> (pad_count == '0 && pad_shift == '0 && pad_odd_idx == 3'd0)); // R11

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) out_live |-> (pad_ovf == $past(&vtx_count[W-1:W-3]))); // R11

    AST_SMALL_RULE: assert property (@(posedge clk) disable iff (!rst_n) (out_live && $past(vtx_count) < W'(SMALL_LIMIT)) |-> (pad_count == (($past(vtx_count) & ~W'(3)) + W'(4)))); // R3

endmodule

// File: tb/tb_pad_vtx_count.sv
module tb_pad_vtx_count;

    localparam int W  = 32;
    localparam int SW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  vtx_count = '0;
    logic [W-1:0]  pad_count;
    logic [SW-1:0] pad_shift;
    logic [2:0]    pad_odd_idx;
    logic          pad_ovf;

    int n_checks = 0;
    int n_fails  = 0;

    pad_vtx_count #(.W(W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .vtx_count   (vtx_count),
        .pad_count   (pad_count),
        .pad_shift   (pad_shift),
        .pad_odd_idx (pad_odd_idx),
        .pad_ovf     (pad_ovf)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Arithmetic model: padded value in 64 bits, then factor into odd * 2^k.
    task automatic model(input longint c, output longint pad, output int sh,
                         output int m, output bit ovf, output string tag);
        int p;
        int n;
        int pat;
        longint t;
        p = 0;
        for (int i = 0; i < W; i++) if (c[i]) p = i;
        if (c < 20) begin
            pad = ((c / 4) + 1) * 4;
            tag = "R3";
        end else begin
            n   = p - 3;
            pat = int'(c >> n) & 15;
            if (pat == 8)       begin pad = 64'd9 << n;       tag = "R4"; end
            else if (pat == 9)  begin pad = 64'd5 << (n + 1); tag = "R5"; end
            else if (pat <= 11) begin pad = 64'd3 << (n + 2); tag = "R6"; end
            else if (pat <= 13) begin pad = 64'd7 << (n + 1); tag = "R7"; end
            else                begin pad = 64'd1 << (n + 4); tag = "R8"; end
        end
        ovf = (pad >= (64'd1 << W));
        sh = 0;
        t = pad;
        while (t % 2 == 0) begin t = t / 2; sh++; end
        m = int'((t - 1) / 2);
        if (ovf) begin pad = 0; sh = 0; m = 0; end
    endtask

    // Drive one count at a falling edge, compare at the next falling edge.
    task automatic apply(input longint c);
        longint pad;
        int sh;
        int m;
        bit ovf;
        string tag;
        vtx_count = W'(c);
        @(negedge clk);
        model(c, pad, sh, m, ovf, tag);
        chk(pad_count == W'(pad), tag, longint'(pad_count), pad);
        chk(int'(pad_shift) == sh && int'(pad_odd_idx) == m, tag,
            longint'(pad_shift) * 8 + pad_odd_idx, longint'(sh) * 8 + m);
        chk(pad_ovf == ovf, "R11", pad_ovf, ovf);
        if (!ovf) begin
            chk(pad > c && pad % 4 == 0, "R9", pad_count, c);
            chk(pad_count == (W'({pad_odd_idx, 1'b1}) << pad_shift) && pad_odd_idx <= 4,
                "R10", pad_count, longint'(2 * int'(pad_odd_idx) + 1) << pad_shift);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset with a nonzero input must still give zero outputs.
        vtx_count = 32'd70;
        repeat (3) @(negedge clk);
        chk(pad_count == 0 && pad_shift == 0 && pad_odd_idx == 0 && !pad_ovf, "R1",
            pad_count, 0);
        rst_n = 1'b1;

        // R2: one-cycle latency, then change every cycle.
        vtx_count = 32'd70;
        @(negedge clk);
        chk(pad_count == 72 && pad_shift == 3 && pad_odd_idx == 4, "R2 R4", pad_count, 72);
        vtx_count = 32'd5;
        @(negedge clk);
        chk(pad_count == 8, "R2", pad_count, 8);

        // R12: exponent reported as the whole power of two.
        apply(9);
        chk(pad_odd_idx == 1 && pad_shift == 2, "R12", pad_shift, 2);
        apply(12);
        chk(pad_odd_idx == 0 && pad_shift == 4, "R12", pad_shift, 4);

        // Exhaustive low range.
        for (int c = 0; c < 4096; c++) apply(c);

        // Leading one at each position, every pattern, three low-bit fills.
        for (int p = 4; p < W; p++) begin
            for (int pat = 8; pat < 16; pat++) begin
                for (int f = 0; f < 3; f++) begin
                    longint lowmask;
                    longint low;
                    lowmask = (64'd1 << (p - 3)) - 1;
                    low = (f == 0) ? 0 : (f == 1) ? lowmask : (64'h5555_5555 & lowmask);
                    apply((longint'(pat) << (p - 3)) | low);
                end
            end
        end

        // R11: overflow edges.
        apply(64'hDFFF_FFFF);
        chk(!pad_ovf && pad_count == 32'hE000_0000, "R11", pad_count, 64'hE000_0000);
        apply(64'hE000_0000);
        chk(pad_ovf && pad_count == 0, "R11", pad_ovf, 1);
        apply(64'hFFFF_FFFF);
        chk(pad_ovf && pad_count == 0 && pad_shift == 0, "R11", pad_ovf, 1);
        apply(0);
        chk(pad_count == 4 && !pad_ovf, "R3", pad_count, 4);

        // R1: reset again mid-run clears the outputs.
        rst_n = 1'b0;
        @(negedge clk);
        chk(pad_count == 0 && !pad_ovf, "R1", pad_count, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule